// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a compact 16-bit processor built around one accumulator. Every instruction passes through three visible states: the instruction word is fetched and the program counter advanced, the operand is read, and the result is applied. Program and data live together in one 256-word memory. The memory's contents come from a parameter and are reloaded on every reset, so a surrounding design or bench supplies the program as an elaboration constant.

Peripherals are reached in two ways. Dedicated input and output instructions always use the I/O port. Ordinary load, arithmetic, logic and store instructions use the I/O port when their operand address falls in the top window of the address space. A single-step enable gates every state transition, so the core can be advanced one state at a time, for example from a debounced push button. Debug outputs show the program counter, the accumulator, the instruction register and the current state.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC, AC and IR are cleared to zero and the state becomes fetch. `io_rd` and `io_wr` are low in the fetch state.
- R2: The state is encoded as fetch=0, decode=1 and execute=2. With `step_en` high, the state moves fetch→decode→execute→fetch. The fetch edge loads IR from the word at PC and increments PC by one. `io_rd` may be high only in decode and `io_wr` only in execute.
- R3: A cycle with `step_en` low changes no state, PC, AC or IR, and keeps `io_rd` and `io_wr` low.
- R4: An instruction word holds the opcode in bits 15:8 and the address or immediate in bits 7:0. Opcode 0x01 loads AC from the address. Opcode 0x02 stores AC to the address. Opcode 0x0E loads AC with the zero-extended immediate. AC changes only on the execute edge.
- R5: Opcode 0x03 adds the operand to AC and opcode 0x04 subtracts it from AC, both modulo 2^16.
- R6: Opcodes 0x05, 0x06 and 0x07 combine AC with the operand by AND, OR and XOR. Opcode 0x08 inverts every bit of AC.
- R7: Opcode 0x09 jumps unconditionally. Opcode 0x0A jumps only when AC is zero. Opcode 0x0B jumps only when AC bit 15 is set. A jump loads PC from bits 7:0 on the execute edge. A jump that is not taken leaves PC at the next instruction.
- R8: A data address at or above `IO_BASE` (default 0xF0) is memory-mapped I/O. Reads by opcodes 0x01, 0x03 to 0x07 raise `io_rd` for one enabled decode cycle and take `io_rdata`. A store raises `io_wr` in execute with `io_wdata` equal to AC. Lower addresses use the memory and raise no strobe.
- R9: Opcode 0x0C loads AC from `io_rdata` through an `io_rd` strobe. Opcode 0x0D raises `io_wr` with AC. Both put instruction bits 7:0 on `io_addr`, whatever the address.
- R10: Opcode 0x00 and every unassigned opcode change nothing except advancing PC.
- R11: After reset, memory word k holds `INIT[16k+15:16k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Allows one state transition on this edge |
| io_addr | output | 8 | I/O address, taken from instruction bits 7:0 |
| io_wdata | output | 16 | I/O write data (accumulator) |
| io_rdata | input | 16 | I/O read data, sampled on an `io_rd` edge |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| dbg_pc | output | 8 | Program counter |
| dbg_ac | output | 16 | Accumulator |
| dbg_ir | output | 16 | Instruction register |
| dbg_state | output | 2 | Current state (0 fetch, 1 decode, 2 execute) |

## Verification
A looping program that uses every opcode runs twice, with a reset between the runs. A bench-side instruction model checks PC, AC, the strobes and the I/O data after every instruction. The I/O read data is random but biased toward zero, 0x8000 and 0xFFFF. That bias separates taken from untaken zero and negative branches, exposes carry and borrow wrap, and tells apart the paths through memory and through the I/O window. A random `step_en` with one cycle in four held low separates true single-stepping from free running. A fixed 0x7FFF + 1 sequence forces the sign-flip branch.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2
  } cpu_state_t;

  localparam logic [OPC_W-1:0] OP_NOP   = 8'h00;
  localparam logic [OPC_W-1:0] OP_LOAD  = 8'h01;
  localparam logic [OPC_W-1:0] OP_STORE = 8'h02;
  localparam logic [OPC_W-1:0] OP_ADD   = 8'h03;
  localparam logic [OPC_W-1:0] OP_SUB   = 8'h04;
  localparam logic [OPC_W-1:0] OP_AND   = 8'h05;
  localparam logic [OPC_W-1:0] OP_OR    = 8'h06;
  localparam logic [OPC_W-1:0] OP_XOR   = 8'h07;
  localparam logic [OPC_W-1:0] OP_NOT   = 8'h08;
  localparam logic [OPC_W-1:0] OP_JUMP  = 8'h09;
  localparam logic [OPC_W-1:0] OP_JZERO = 8'h0A;
  localparam logic [OPC_W-1:0] OP_JNEG  = 8'h0B;
  localparam logic [OPC_W-1:0] OP_IN    = 8'h0C;
  localparam logic [OPC_W-1:0] OP_OUT   = 8'h0D;
  localparam logic [OPC_W-1:0] OP_LDI   = 8'h0E;

  // Opcodes whose operand is a data address read during decode
  function automatic logic op_reads_data(input logic [OPC_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) ||
           (op == OP_AND)  || (op == OP_OR)  || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter logic [(2**AW)*DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] iaddr,
  output logic [DW-1:0] idata,
  input  logic [AW-1:0] daddr,
  output logic [DW-1:0] ddata,
  input  logic          we,
  input  logic [DW-1:0] wdata
);
  localparam int WORDS = 2**AW;

  logic [DW-1:0] words [WORDS];

  // Reset reloads the program image so every run starts identically
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < WORDS; k++) words[k] <= INIT[k*DW +: DW];
    end else if (we) begin
      words[daddr] <= wdata;
    end
  end

  assign idata = words[iaddr];
  assign ddata = words[daddr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic [OPC_W-1:0] op,
  input  logic [DW-1:0]    acc,
  input  logic [DW-1:0]    opd,
  input  logic [AW-1:0]    imm,
  output logic [DW-1:0]    result,
  output logic             acc_we
);
  function automatic logic [DW-1:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] f_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DW-1:0] f_bool(input logic [1:0] sel,
                                           input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (sel)
      2'd0:    return a & b;
      2'd1:    return a | b;
      2'd2:    return a ^ b;
      default: return ~a;
    endcase
  endfunction

  always_comb begin
    result = acc;
    acc_we = 1'b1;
    case (op)
      OP_LOAD, OP_IN: result = opd;
      OP_LDI:         result = {{(DW-AW){1'b0}}, imm};
      OP_ADD:         result = f_add(acc, opd);
      OP_SUB:         result = f_sub(acc, opd);
      OP_AND:         result = f_bool(2'd0, acc, opd);
      OP_OR:          result = f_bool(2'd1, acc, opd);
      OP_XOR:         result = f_bool(2'd2, acc, opd);
      OP_NOT:         result = f_bool(2'd3, acc, opd);
      default:        acc_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic [DW-1:0] fetch_word,
  input  logic          ac_zero,
  input  logic          ac_neg,
  output cpu_state_t    state,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic          fetch_fire,
  output logic          decode_fire,
  output logic          exec_fire,
  output logic          branch_take
);
  logic [OPC_W-1:0] opcode;
  logic [AW-1:0]    target;

  assign opcode = ir[DW-1 -: OPC_W];
  assign target = ir[AW-1:0];

  assign fetch_fire  = step_en && (state == ST_FETCH);
  assign decode_fire = step_en && (state == ST_DECODE);
  assign exec_fire   = step_en && (state == ST_EXEC);

  assign branch_take = exec_fire &&
                       ((opcode == OP_JUMP) ||
                        ((opcode == OP_JZERO) && ac_zero) ||
                        ((opcode == OP_JNEG)  && ac_neg));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else if (step_en) begin
      case (state)
        ST_FETCH: begin
          ir    <= fetch_word;
          pc    <= pc + 1'b1;
          state <= ST_DECODE;
        end
        ST_DECODE: state <= ST_EXEC;
        ST_EXEC: begin
          if (branch_take) pc <= target;
          state <= ST_FETCH;
        end
        default: state <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] IO_BASE = 8'hF0,
  parameter logic [(2**AW)*DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  output logic [AW-1:0] io_addr,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata,
  output logic          io_rd,
  output logic          io_wr,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_ac,
  output logic [DW-1:0] dbg_ir,
  output logic [1:0]    dbg_state
);
  cpu_state_t       state;
  logic [AW-1:0]    pc;
  logic [DW-1:0]    ir;
  logic [DW-1:0]    ac;
  logic [DW-1:0]    mdr;
  logic [DW-1:0]    fetch_word;
  logic [DW-1:0]    mem_rdata;
  logic [OPC_W-1:0] opcode;
  logic [AW-1:0]    operand;
  logic             fetch_fire, decode_fire, exec_fire, branch_take;
  logic             data_is_io, wants_operand, io_read_sel;
  logic             mem_we;
  logic [DW-1:0]    alu_res;
  logic             alu_we;

  assign opcode        = ir[DW-1 -: OPC_W];
  assign operand       = ir[AW-1:0];
  assign data_is_io    = (operand >= IO_BASE);
  assign wants_operand = op_reads_data(opcode);
  assign io_read_sel   = (opcode == OP_IN) || (wants_operand && data_is_io);

  acc_cpu_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .fetch_word (fetch_word),
    .ac_zero    (ac == '0),
    .ac_neg     (ac[DW-1]),
    .state      (state),
    .pc         (pc),
    .ir         (ir),
    .fetch_fire (fetch_fire),
    .decode_fire(decode_fire),
    .exec_fire  (exec_fire),
    .branch_take(branch_take)
  );

  assign mem_we = exec_fire && (opcode == OP_STORE) && !data_is_io;

  acc_cpu_mem #(.DW(DW), .AW(AW), .INIT(INIT)) u_mem (
    .clk  (clk),
    .rst  (rst),
    .iaddr(pc),
    .idata(fetch_word),
    .daddr(operand),
    .ddata(mem_rdata),
    .we   (mem_we),
    .wdata(ac)
  );

  acc_cpu_alu #(.DW(DW), .AW(AW)) u_alu (
    .op    (opcode),
    .acc   (ac),
    .opd   (mdr),
    .imm   (operand),
    .result(alu_res),
    .acc_we(alu_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ac  <= '0;
      mdr <= '0;
    end else begin
      if (decode_fire) mdr <= io_read_sel ? io_rdata : mem_rdata;
      if (exec_fire && alu_we) ac <= alu_res;
    end
  end

  assign io_addr  = operand;
  assign io_wdata = ac;
  assign io_rd    = decode_fire && io_read_sel;
  assign io_wr    = exec_fire && ((opcode == OP_OUT) ||
                                  ((opcode == OP_STORE) && data_is_io));

  assign dbg_pc    = pc;
  assign dbg_ac    = ac;
  assign dbg_ir    = ir;
  assign dbg_state = state;

  logic unused_ok;
  assign unused_ok = fetch_fire;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          step_en,
  input logic [1:0]    state,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] ac,
  input logic [DW-1:0] ir,
  input logic          io_rd,
  input logic          io_wr,
  input logic          mem_we,
  input logic          exec_fire,
  input logic          branch_take
);
  assert_fetch_next_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && state == 2'd0) |=> (state == 2'd1));
  assert_decode_next_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && state == 2'd1) |=> (state == 2'd2));
  assert_exec_next_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && state == 2'd2) |=> (state == 2'd0));
  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && state == 2'd0) |=> (pc == $past(pc) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(pc) && $stable(ac) && $stable(ir) && $stable(state)));
  assert_ac_exec_only_R4: assert property (@(posedge clk) disable iff (rst)
    (state != 2'd2) |=> $stable(ac));
  assert_rd_window_R8: assert property (@(posedge clk) disable iff (rst)
    io_rd |-> (step_en && state == 2'd1));
  assert_wr_window_R8: assert property (@(posedge clk) disable iff (rst)
    io_wr |-> (step_en && state == 2'd2));
  assert_single_access_R8: assert property (@(posedge clk) disable iff (rst)
    $countones({io_rd, io_wr, mem_we}) <= 1);
  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    branch_take |=> (pc == $past(ir[AW-1:0])));
  assert_no_jump_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_fire && !branch_take) |=> $stable(pc));
endmodule

bind acc_cpu_core acc_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_en    (step_en),
  .state      (dbg_state),
  .pc         (dbg_pc),
  .ac         (dbg_ac),
  .ir         (dbg_ir),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .mem_we     (mem_we),
  .exec_fire  (exec_fire),
  .branch_take(branch_take)
);

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int NW = 256;
  localparam logic [AW-1:0] IOB = 8'hF0;

  function automatic logic [NW*DW-1:0] build_image();
    logic [NW*DW-1:0] img;
    img = '0;
    img[8'h00*DW +: DW] = 16'h0CF1; // IN F1
    img[8'h01*DW +: DW] = 16'h0280; // STORE 80
    img[8'h02*DW +: DW] = 16'h0CF2; // IN F2
    img[8'h03*DW +: DW] = 16'h0380; // ADD 80
    img[8'h04*DW +: DW] = 16'h0DF3; // OUT F3
    img[8'h05*DW +: DW] = 16'h0480; // SUB 80
    img[8'h06*DW +: DW] = 16'h0581; // AND 81
    img[8'h07*DW +: DW] = 16'h0682; // OR 82
    img[8'h08*DW +: DW] = 16'h0780; // XOR 80
    img[8'h09*DW +: DW] = 16'h02F5; // STORE F5 (mapped)
    img[8'h0A*DW +: DW] = 16'h0B0D; // JN 0D
    img[8'h0B*DW +: DW] = 16'h0800; // NOT
    img[8'h0C*DW +: DW] = 16'h0DF3; // OUT F3
    img[8'h0D*DW +: DW] = 16'h01F4; // LOAD F4 (mapped)
    img[8'h0E*DW +: DW] = 16'h0A12; // JZ 12
    img[8'h0F*DW +: DW] = 16'h0E00; // LDI 0
    img[8'h10*DW +: DW] = 16'h0A12; // JZ 12 (taken)
    img[8'h11*DW +: DW] = 16'h0DF3; // skipped
    img[8'h12*DW +: DW] = 16'h0183; // LOAD 83
    img[8'h13*DW +: DW] = 16'h0384; // ADD 84 -> 8000
    img[8'h14*DW +: DW] = 16'h0B16; // JN 16 (taken)
    img[8'h15*DW +: DW] = 16'h0DF3; // skipped
    img[8'h16*DW +: DW] = 16'h0DF3; // OUT F3
    img[8'h17*DW +: DW] = 16'h0E5A; // LDI 5A
    img[8'h18*DW +: DW] = 16'hFF00; // unassigned opcode
    img[8'h19*DW +: DW] = 16'h0000; // NOP
    img[8'h1A*DW +: DW] = 16'h0900; // JUMP 00
    img[8'h81*DW +: DW] = 16'h0FF0;
    img[8'h82*DW +: DW] = 16'h8001;
    img[8'h83*DW +: DW] = 16'h7FFF;
    img[8'h84*DW +: DW] = 16'h0001;
    return img;
  endfunction

  localparam logic [NW*DW-1:0] IMG = build_image();

  logic          clk = 1'b0;
  logic          rst;
  logic          step_en;
  logic [DW-1:0] io_rdata;
  logic [AW-1:0] io_addr;
  logic [DW-1:0] io_wdata;
  logic          io_rd, io_wr;
  logic [AW-1:0] dbg_pc;
  logic [DW-1:0] dbg_ac, dbg_ir;
  logic [1:0]    dbg_state;

  always #2 clk = ~clk;

  acc_cpu_core #(.DW(DW), .AW(AW), .IO_BASE(IOB), .INIT(IMG)) u0 (
    .clk(clk), .rst(rst), .step_en(step_en),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rd(io_rd), .io_wr(io_wr),
    .dbg_pc(dbg_pc), .dbg_ac(dbg_ac), .dbg_ir(dbg_ir), .dbg_state(dbg_state)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [DW-1:0] iss_mem [NW];
  logic [AW-1:0] iss_pc;
  logic [DW-1:0] iss_ac;
  logic [DW-1:0] cap_rd;
  bit            pend;
  string         pend_req;
  bit            have_prev, prev_step;
  logic [AW-1:0] p_pc;
  logic [DW-1:0] p_ac, p_ir;
  logic [1:0]    p_state;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] ref_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b1, a} - {1'b0, b};
    return s[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] ref_bits(input int kind, input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) begin
      case (kind)
        0: r[i] = (a[i] == 1'b1) && (b[i] == 1'b1);
        1: r[i] = (a[i] == 1'b1) || (b[i] == 1'b1);
        2: r[i] = (a[i] != b[i]);
        default: r[i] = (a[i] == 1'b0);
      endcase
    end
    return r;
  endfunction

  function automatic bit ref_reads_io(input logic [DW-1:0] ins);
    logic [7:0] op;
    op = ins[15:8];
    if (op == 8'h0C) return 1'b1;
    if (op == 8'h01 || (op >= 8'h03 && op <= 8'h07)) return ins[7:0] >= IOB;
    return 1'b0;
  endfunction

  task automatic iss_init();
    for (int i = 0; i < NW; i++) iss_mem[i] = IMG[i*DW +: DW];
    iss_pc = '0;
    iss_ac = '0;
    pend = 1'b0;
    have_prev = 1'b0;
  endtask

  task automatic iss_exec(output bit wr, output logic [AW-1:0] waddr,
                          output logic [DW-1:0] wdata, output string req);
    logic [DW-1:0] ins, v;
    logic [7:0] op;
    logic [AW-1:0] a;
    ins = iss_mem[iss_pc];
    op = ins[15:8];
    a = ins[7:0];
    v = (a >= IOB) ? cap_rd : iss_mem[a];
    iss_pc = iss_pc + 8'd1;
    wr = 1'b0;
    waddr = a;
    wdata = iss_ac;
    req = "R10";
    case (op)
      8'h01: begin iss_ac = v; req = (a >= IOB) ? "R8" : "R4"; end
      8'h02: begin
        if (a >= IOB) begin wr = 1'b1; req = "R8"; end
        else begin iss_mem[a] = iss_ac; req = "R4"; end
      end
      8'h03: begin iss_ac = ref_add(iss_ac, v); req = "R5"; end
      8'h04: begin iss_ac = ref_sub(iss_ac, v); req = "R5"; end
      8'h05: begin iss_ac = ref_bits(0, iss_ac, v); req = "R6"; end
      8'h06: begin iss_ac = ref_bits(1, iss_ac, v); req = "R6"; end
      8'h07: begin iss_ac = ref_bits(2, iss_ac, v); req = "R6"; end
      8'h08: begin iss_ac = ref_bits(3, iss_ac, v); req = "R6"; end
      8'h09: begin iss_pc = a; req = "R7"; end
      8'h0A: begin if (iss_ac == 16'h0000) iss_pc = a; req = "R7"; end
      8'h0B: begin if (iss_ac >= 16'h8000) iss_pc = a; req = "R7"; end
      8'h0C: begin iss_ac = cap_rd; req = "R9"; end
      8'h0D: begin wr = 1'b1; req = "R9"; end
      8'h0E: begin iss_ac = {8'h00, a}; req = "R4"; end
      default: req = "R10";
    endcase
  endtask

  task automatic check_reset_state();
    chk(dbg_pc == 8'h00, "R1", "pc after reset", dbg_pc, 0);
    chk(dbg_ac == 16'h0000, "R1", "ac after reset", dbg_ac, 0);
    chk(dbg_ir == 16'h0000, "R1", "ir after reset", dbg_ir, 0);
    chk(dbg_state == 2'd0, "R1", "state after reset", dbg_state, 0);
    chk(!io_rd && !io_wr, "R1", "strobes after reset", {io_rd, io_wr}, 0);
  endtask

  task automatic run_cycles(input int n);
    for (int c = 0; c < n; c++) begin
      bit wr, er;
      logic [AW-1:0] waddr;
      logic [DW-1:0] wdata, ins;
      string req;
      @(negedge clk);
      step_en = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 7))
        0: io_rdata = 16'h0000;
        1: io_rdata = 16'h8000;
        2: io_rdata = 16'hFFFF;
        default: io_rdata = DW'($urandom);
      endcase
      #1;
      if (have_prev && !prev_step) begin
        chk(dbg_pc == p_pc && dbg_ir == p_ir && dbg_state == p_state, "R3",
            "pc/ir/state hold", {dbg_pc, dbg_state}, {p_pc, p_state});
        chk(dbg_ac == p_ac, "R3", "ac hold", dbg_ac, p_ac);
      end
      if (pend) begin
        chk(dbg_state == 2'd0, "R2", "state after execute", dbg_state, 0);
        chk(dbg_pc == iss_pc, pend_req, "pc after instruction", dbg_pc, iss_pc);
        chk(dbg_ac == iss_ac, pend_req, "ac after instruction", dbg_ac, iss_ac);
        pend = 1'b0;
      end
      if (!step_en) begin
        chk(!io_rd && !io_wr, "R3", "strobes while stalled", {io_rd, io_wr}, 0);
      end else if (dbg_state == 2'd1) begin
        ins = iss_mem[iss_pc];
        chk(dbg_ir == ins, "R11", "fetched word", dbg_ir, ins);
        chk(dbg_pc == iss_pc + 8'd1, "R2", "pc after fetch", dbg_pc, iss_pc + 8'd1);
        er = ref_reads_io(ins);
        chk(io_rd == er, "R8", "read strobe", io_rd, er);
        if (er) chk(io_addr == ins[7:0], "R9", "read address", io_addr, ins[7:0]);
        chk(!io_wr, "R2", "no write in decode", io_wr, 0);
        cap_rd = io_rdata;
      end else if (dbg_state == 2'd2) begin
        iss_exec(wr, waddr, wdata, req);
        chk(io_wr == wr, req, "write strobe", io_wr, wr);
        if (wr) begin
          chk(io_addr == waddr, req, "write address", io_addr, waddr);
          chk(io_wdata == wdata, req, "write data", io_wdata, wdata);
        end
        chk(!io_rd, "R2", "no read in execute", io_rd, 0);
        pend = 1'b1;
        pend_req = req;
      end else begin
        chk(!io_rd && !io_wr, "R2", "no strobe in fetch", {io_rd, io_wr}, 0);
      end
      p_pc = dbg_pc; p_ac = dbg_ac; p_ir = dbg_ir; p_state = dbg_state;
      prev_step = step_en;
      have_prev = 1'b1;
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    step_en = 1'b0;
    io_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_reset_state();
    iss_init();
    run_cycles(4000);
    @(negedge clk);
    rst = 1'b1;
    step_en = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step_en = 1'b0;
    #1;
    check_reset_state();
    iss_init();
    run_cycles(3000);
    report();
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end
endmodule